// File: doc/BRIEF.md
# Interleaved Thread Issue Scheduler

This block picks, on every clock cycle, at most one hardware thread that may send its next instruction into a deep, fixed-length, in-order pipeline. Any thread can win any cycle, so consecutive issue slots usually belong to different threads. Switching threads this way hides long memory latencies without caches. Fetch, decode, register files and the memory system sit outside the block. The block only decides who may issue, and it keeps the per-thread bookkeeping that makes the decision safe.

For each thread the scheduler counts the instructions still inside the pipeline and the memory operations not yet completed. It also keeps a credit taken from the compiler's lookahead hint. The hint says how many later instructions of the same thread do not depend on the current one. A thread is a candidate only if all of the following hold:

- it requests;
- its pipeline is empty, or it still holds credit;
- a memory instruction would not exceed the per-thread outstanding cap;
- the pipeline as a whole has a free stage.

Among the candidates, a round-robin search begins one past the last winner. Pipeline-exit and memory-completion pulses are tagged with a thread number. Completions may arrive in any order. A completion that matches nothing is reported and otherwise dropped.

Top module: `ilv_issue_sched`

## Requirements
- R1: After synchronous reset, `iss_vld` and `cpl_err` are 0, and the first grant made while all threads request goes to thread 0.
- R2: Each grant appears on `iss_vld`/`iss_tid` one clock after the inputs that caused it. Only a requesting, eligible thread is granted. The search order starts one past the previously granted thread and skips non-requesting threads.
- R3: In a cycle with no eligible thread, `iss_vld` is 0 one clock later (a bubble).
- R4: A thread whose last issued instruction carried lookahead 0 cannot issue again until an exit pulse for it is seen. After the edge that takes the exit, it is granted on the following decision.
- R5: Credit rule. An instruction issued into an empty pipeline sets the thread's credit to its lookahead L. An instruction issued on credit sets the credit to min(credit−1, L). A non-empty thread with zero credit is ineligible. With L=2 on every instruction, exactly 3 issues happen back to back.
- R6: Lookahead values above MAXLA (8) are treated as MAXLA. With 15 on every instruction, exactly 9 back-to-back issues happen.
- R7: A memory instruction (`mem_op`=1) is ineligible while its thread has MEMCAP (8) operations outstanding. Pipeline exits do not lift this block.
- R8: Each completion pulse frees exactly one outstanding slot of the tagged thread, in any order across threads. A freed thread can then issue one memory instruction.
- R9: A completion tagged for a thread with no outstanding operations sets `cpl_err` for one cycle (one clock later) and leaves the thread's count unchanged.
- R10: The total number of instructions in the pipeline never exceeds DEPTH (21). Once it is reached, no grant is made until an exit pulse arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NTHR | Per-thread request: next instruction is ready |
| la_hint | input | NTHR*LAW | Per-thread lookahead of the candidate instruction, thread t at bits [t*LAW +: LAW] |
| mem_op | input | NTHR | Per-thread: candidate instruction is a memory operation |
| exit_vld | input | 1 | An instruction left the pipeline |
| exit_tid | input | TW | Thread of the exiting instruction |
| done_vld | input | 1 | A memory operation completed |
| done_tid | input | TW | Thread of the completed memory operation |
| iss_vld | output | 1 | Registered: a thread was granted |
| iss_tid | output | TW | Registered: granted thread |
| cpl_err | output | 1 | Registered: the last completion matched no outstanding operation |

## Verification
The assertions check on every cycle that a granted thread was eligible in its own context. They also check that the pipeline, credit and outstanding counters stay inside their bounds, that a full pipeline produces no grant, and that an unmatched completion leaves the count at zero. Only the directed scenarios can show the exact grant order, the length of each issue burst under the credit rule, the clamping of oversized hints, and the bubble that follows an exit or completion. They also show that dropped completions really have no effect on a later burst of memory issues.

// File: rtl/ilv_sched_pkg.sv
package ilv_sched_pkg;

  function automatic int unsigned clamp_hint(int unsigned hint, int unsigned maxv);
    return (hint > maxv) ? maxv : hint;
  endfunction

endpackage

// File: rtl/ilv_thr_ctx.sv
module ilv_thr_ctx #(
  parameter int MAXLA  = 8,
  parameter int MEMCAP = 8,
  parameter int LAW    = 4,
  parameter int PW     = 4,
  parameter int OW     = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req,
  input  logic [LAW-1:0] hint,
  input  logic           mem,
  input  logic           grant,
  input  logic           exit_hit,
  input  logic           done_hit,
  output logic           elig_o,
  output logic           exit_ok_o,
  output logic           bad_done_o
);
  import ilv_sched_pkg::*;

  logic [PW-1:0]  inpipe, inpipe_nx, inpipe_rem;
  logic [LAW-1:0] credit, credit_nx, hint_c, credit_dec;
  logic [OW-1:0]  outst, outst_nx;
  logic           pipe_ok, mem_ok, done_ok;

  assign hint_c     = LAW'(clamp_hint(int'(hint), MAXLA));
  assign exit_ok_o  = exit_hit && (inpipe != '0);
  assign done_ok    = done_hit && (outst != '0);
  assign bad_done_o = done_hit && (outst == '0);
  assign pipe_ok    = (inpipe == '0) || (credit != '0);
  assign mem_ok     = !mem || (int'(outst) < MEMCAP);
  assign elig_o     = req && pipe_ok && mem_ok;

  assign inpipe_rem = inpipe - PW'(exit_ok_o);
  assign credit_dec = credit - LAW'(1);

  always_comb begin
    inpipe_nx = inpipe_rem + PW'(grant);
    outst_nx  = outst + OW'(grant && mem) - OW'(done_ok);
    credit_nx = credit;
    if (grant) begin
      if (inpipe_rem == '0) credit_nx = hint_c;
      else credit_nx = (credit_dec < hint_c) ? credit_dec : hint_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inpipe <= '0;
      credit <= '0;
      outst  <= '0;
    end else begin
      inpipe <= inpipe_nx;
      credit <= credit_nx;
      outst  <= outst_nx;
    end
  end

  // grant from arbiter must match this context's eligibility
  assert_grant_elig_R2: assert property (@(posedge clk) disable iff (rst)
    grant |-> elig_o);
  assert_pipe_bound_R5: assert property (@(posedge clk) disable iff (rst)
    int'(inpipe) <= MAXLA + 1);
  assert_credit_bound_R6: assert property (@(posedge clk) disable iff (rst)
    int'(credit) <= MAXLA);
  assert_mem_cap_R7: assert property (@(posedge clk) disable iff (rst)
    int'(outst) <= MEMCAP);
  assert_bad_done_R9: assert property (@(posedge clk) disable iff (rst)
    (bad_done_o && !(grant && mem)) |=> (outst == '0));

endmodule

// File: rtl/ilv_rr_pick.sv
module ilv_rr_pick #(
  parameter int NTHR = 8,
  parameter int TW   = 3
) (
  input  logic [NTHR-1:0] elig,
  input  logic [TW-1:0]   last,
  output logic            found,
  output logic [TW-1:0]   idx
);
  always_comb begin
    int j;
    found = 1'b0;
    idx   = '0;
    j     = 0;
    for (int k = NTHR; k >= 1; k--) begin
      j = (int'(last) + k) % NTHR;
      if (elig[j]) begin
        found = 1'b1;
        idx   = TW'(j);
      end
    end
  end
endmodule

// File: rtl/ilv_issue_sched.sv
module ilv_issue_sched #(
  parameter int NTHR   = 8,
  parameter int DEPTH  = 21,
  parameter int MAXLA  = 8,
  parameter int MEMCAP = 8,
  parameter int TW     = $clog2(NTHR),
  parameter int LAW    = $clog2(MAXLA + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NTHR-1:0]   req,
  input  logic [NTHR*LAW-1:0] la_hint,
  input  logic [NTHR-1:0]   mem_op,
  input  logic              exit_vld,
  input  logic [TW-1:0]     exit_tid,
  input  logic              done_vld,
  input  logic [TW-1:0]     done_tid,
  output logic              iss_vld,
  output logic [TW-1:0]     iss_tid,
  output logic              cpl_err
);
  localparam int PW   = $clog2(MAXLA + 2);
  localparam int OW   = $clog2(MEMCAP + 1);
  localparam int TOTW = $clog2(DEPTH + 1);

  logic [NTHR-1:0] elig, exit_ok, bad_done, gvec, cand;
  logic [TW-1:0]   last, pick;
  logic            found, room;
  logic [TOTW-1:0] tot;

  assign room = (int'(tot) < DEPTH);
  assign cand = elig & {NTHR{room}};
  assign gvec = found ? (NTHR'(1) << pick) : '0;

  for (genvar t = 0; t < NTHR; t++) begin : g_thr
    ilv_thr_ctx #(
      .MAXLA(MAXLA), .MEMCAP(MEMCAP), .LAW(LAW), .PW(PW), .OW(OW)
    ) u_ctx (
      .clk       (clk),
      .rst       (rst),
      .req       (req[t]),
      .hint      (la_hint[t*LAW +: LAW]),
      .mem       (mem_op[t]),
      .grant     (gvec[t]),
      .exit_hit  (exit_vld && (exit_tid == TW'(t))),
      .done_hit  (done_vld && (done_tid == TW'(t))),
      .elig_o    (elig[t]),
      .exit_ok_o (exit_ok[t]),
      .bad_done_o(bad_done[t])
    );
  end

  ilv_rr_pick #(.NTHR(NTHR), .TW(TW)) u_pick (
    .elig (cand),
    .last (last),
    .found(found),
    .idx  (pick)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      iss_vld <= 1'b0;
      iss_tid <= '0;
      cpl_err <= 1'b0;
      last    <= TW'(NTHR - 1);
      tot     <= '0;
    end else begin
      iss_vld <= found;
      cpl_err <= |bad_done;
      tot     <= tot + TOTW'(found) - TOTW'(|exit_ok);
      if (found) begin
        iss_tid <= pick;
        last    <= pick;
      end
    end
  end

  assert_depth_bound_R10: assert property (@(posedge clk) disable iff (rst)
    int'(tot) <= DEPTH);
  assert_full_no_grant_R10: assert property (@(posedge clk) disable iff (rst)
    (int'(tot) == DEPTH) |-> !found);
  assert_single_grant_R2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gvec & elig));

endmodule

// File: tb/sim_ilv_issue_sched.sv
module sim_ilv_issue_sched;
  localparam int NTHR = 8, DEPTH = 21, MAXLA = 8, MEMCAP = 8;
  localparam int TW = 3, LAW = 4;

  logic clk = 0, rst = 1;
  logic [NTHR-1:0] req = '0, mem_op = '0;
  logic [NTHR*LAW-1:0] la_hint = '0;
  logic exit_vld = 0, done_vld = 0;
  logic [TW-1:0] exit_tid = '0, done_tid = '0;
  logic iss_vld, cpl_err;
  logic [TW-1:0] iss_tid;

  int checks = 0, errors = 0;
  bit finished = 0;
  int tids[64];

  always #10 clk = ~clk;

  ilv_issue_sched #(.NTHR(NTHR), .DEPTH(DEPTH), .MAXLA(MAXLA), .MEMCAP(MEMCAP)) u0 (
    .clk(clk), .rst(rst), .req(req), .la_hint(la_hint), .mem_op(mem_op),
    .exit_vld(exit_vld), .exit_tid(exit_tid), .done_vld(done_vld), .done_tid(done_tid),
    .iss_vld(iss_vld), .iss_tid(iss_tid), .cpl_err(cpl_err));

  task automatic chk(string rq, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; req = '0; mem_op = '0; la_hint = '0; exit_vld = 0; done_vld = 0;
    @(negedge clk); @(negedge clk);
    rst = 0;
  endtask

  task automatic set_hint_all(int v);
    for (int t = 0; t < NTHR; t++) la_hint[t*LAW +: LAW] = LAW'(v);
  endtask

  // counts consecutive valid grants sampled at following negedges
  task automatic count_run(int maxc, output int n);
    n = 0;
    for (int c = 0; c < maxc; c++) begin
      @(negedge clk);
      if (!iss_vld) break;
      if (n < 64) tids[n] = int'(iss_tid);
      n++;
    end
  endtask

  task automatic pulse_exit(int t);
    exit_vld = 1; exit_tid = TW'(t);
    @(negedge clk);
    exit_vld = 0;
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    chk("R1 iss_vld after reset", int'(iss_vld), 0);
    chk("R1 cpl_err after reset", int'(cpl_err), 0);
  endtask

  task automatic t_round_robin();
    int n;
    do_reset();
    set_hint_all(8); req = '1;
    count_run(8, n);
    chk("R1 first grant thread 0", tids[0], 0);
    for (int i = 1; i < 8; i++) chk("R2 round-robin order", tids[i], i);
    do_reset();
    set_hint_all(8); req = 8'b0101_0010;
    count_run(6, n);
    chk("R2 skip count", n, 6);
    chk("R2 skip g0", tids[0], 1); chk("R2 skip g1", tids[1], 4);
    chk("R2 skip g2", tids[2], 6); chk("R2 skip g3", tids[3], 1);
  endtask

  task automatic t_drain();
    int n;
    do_reset();
    set_hint_all(0); req = 8'b0000_1000;
    count_run(5, n);
    chk("R4 single issue with lookahead 0", n, 1);
    chk("R4 granted thread", tids[0], 3);
    chk("R3 bubble while blocked", int'(iss_vld), 0);
    pulse_exit(3);
    chk("R4 no grant in exit cycle", int'(iss_vld), 0);
    @(negedge clk);
    chk("R4 grant after exit", int'(iss_vld), 1);
    chk("R4 grant thread after exit", int'(iss_tid), 3);
  endtask

  task automatic t_lookahead();
    int n;
    do_reset();
    set_hint_all(2); req = 8'b0010_0000;
    count_run(20, n);
    chk("R5 burst with lookahead 2", n, 3);
    do_reset();
    set_hint_all(8); req = 8'b0010_0000;
    @(negedge clk);
    set_hint_all(1);
    count_run(20, n);
    chk("R5 credit min rule burst", n + 1, 3);
    do_reset();
    set_hint_all(15); req = 8'b0000_0001;
    count_run(30, n);
    chk("R6 oversized hint clamped", n, 9);
  endtask

  task automatic t_memcap();
    int n;
    do_reset();
    set_hint_all(8); req = 8'b0000_0100; mem_op = '1;
    count_run(20, n);
    chk("R7 issues up to cap", n, 8);
    for (int i = 0; i < 8; i++) pulse_exit(2);
    @(negedge clk);
    chk("R7 exits do not lift cap", int'(iss_vld), 0);
    done_vld = 1; done_tid = 3'd2;
    @(negedge clk);
    done_vld = 0;
    chk("R8 no grant in completion cycle", int'(iss_vld), 0);
    chk("R9 valid completion no error", int'(cpl_err), 0);
    count_run(5, n);
    chk("R8 one issue after completion", n, 1);
  endtask

  task automatic t_out_of_order();
    int n;
    do_reset();
    set_hint_all(8); req = 8'b0000_1010; mem_op = '1;
    count_run(30, n);
    chk("R8 two threads saturate", n, 16);
    done_vld = 1; done_tid = 3'd3;
    @(negedge clk);
    done_vld = 0;
    count_run(5, n);
    chk("R8 later thread freed first", n, 1);
    chk("R8 freed thread granted", tids[0], 3);
    done_vld = 1; done_tid = 3'd1;
    @(negedge clk);
    done_vld = 0;
    count_run(5, n);
    chk("R8 earlier thread freed", n, 1);
    chk("R8 second freed thread", tids[0], 1);
  endtask

  task automatic t_bad_done();
    int n;
    do_reset();
    done_vld = 1; done_tid = 3'd6;
    @(negedge clk);
    done_vld = 0;
    chk("R9 error on stray completion", int'(cpl_err), 1);
    @(negedge clk);
    chk("R9 error is one cycle", int'(cpl_err), 0);
    set_hint_all(8); req = 8'b0100_0000; mem_op = '1;
    count_run(20, n);
    chk("R9 count unchanged by stray completion", n, 8);
  endtask

  task automatic t_depth();
    int n;
    do_reset();
    set_hint_all(8); req = '1;
    count_run(40, n);
    chk("R10 grants limited by depth", n, DEPTH);
    chk("R10 last grant before full", tids[20], 4);
    pulse_exit(0);
    chk("R10 no grant in exit cycle", int'(iss_vld), 0);
    @(negedge clk);
    chk("R10 grant after exit", int'(iss_vld), 1);
    chk("R10 grant continues round-robin", int'(iss_tid), 5);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_round_robin();
    t_drain();
    t_lookahead();
    t_memcap();
    t_out_of_order();
    t_bad_done();
    t_depth();
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule